// File: doc/BRIEF.md
# Self-Synchronizing PRBS Bit-Error Checker

This block sits at the receive end of a serial link under stress test. It watches a stream of single bits that should carry a pseudo-random binary sequence of a chosen order. It aligns an internal reference shift register to that stream by loading it from the received bits. Once aligned, the reference runs on its own feedback. Each new received bit is then compared with the bit the reference predicts.

While aligned, the block keeps two saturating counts: bits examined and bits in error. The bit-error rate is the quotient of the two and is formed outside the block. An error pulse marks each mismatch. A flag shows when enough errors have been seen for a statistically meaningful rate. When errors become dense within a sliding block of bits, the block gives up its alignment and acquires the stream again.

Top module: `prbs_err_checker`

## Requirements
- R1: `orderSel` picks the sequence. 0 gives x^7+x^6+1, 1 gives x^9+x^5+1, 2 gives x^15+x^14+1, 3 gives x^23+x^18+1, and 4 to 7 give x^31+x^28+1. With long tap k and short tap t, the expected bit n is b[n-k] XOR b[n-t].
- R2: With `fbInv`=0 the feedback is plain XOR. With `fbInv`=1 the expected bit is inverted (XNOR feedback), so an XNOR stream never locks a checker set to XOR.
- R3: During acquisition, the first k valid bits only load the reference. Each later mismatch sends acquisition back to that loading step.
- R4: `locked` rises at the edge that accepts the 3k-th valid bit of a clean acquisition, which means k loading bits followed by 2k matching predictions. Cycles with `bitValid` low do not advance acquisition.
- R5: While locked, the reference shifts in its own predicted bit and not the received one. A single corrupted bit therefore costs exactly one error.
- R6: While locked, each valid mismatching bit adds one to `errCount`. `errPulse` is high for the single cycle after that edge.
- R7: The block counts errors within windows of WIN_LEN locked valid bits, with a window starting at lock and again every WIN_LEN bits. The error that brings a window's total to ERR_LIMIT drops `locked`, and acquisition restarts.
- R8: `bitCount` and `errCount` stop at their all-ones value and never wrap.
- R9: `bitCount` grows only for valid bits accepted while locked. `clear` zeroes both counts at the next edge, and this takes priority over any increment in that cycle.
- R10: `enoughErrs` is high exactly when `errCount` is 100 or more.
- R11: Reset leaves the block unlocked with both counts at zero and `errPulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitValid | input | 1 | Marks a received bit in this cycle |
| rxBit | input | 1 | Received serial bit |
| orderSel | input | 3 | Polynomial select (R1) |
| fbInv | input | 1 | 0: XOR feedback, 1: XNOR feedback |
| clear | input | 1 | Zero both counters |
| errCount | output | CNT_W | Saturating count of bit errors |
| bitCount | output | CNT_W | Saturating count of compared bits |
| locked | output | 1 | Reference aligned to the stream |
| errPulse | output | 1 | One-cycle pulse per counted error |
| enoughErrs | output | 1 | Error count has reached 100 |

## Verification
Two conditions are hard to reach from the ports. One is loss of lock at exactly the error-density threshold. The other is counter saturation. The stimulus reaches the first by injecting errors into a correctly generated stream at two rates: one error in every ten bits, which can never fill a window to the limit, and a dense burst, which must. A scoreboard model built from the requirements predicts, bit by bit, the window alignment at which lock drops and the exact point of relock. A narrow counter width set for the bench brings saturation within a few thousand bits.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int HIST_W = 31;

  typedef enum logic {SEEK, TRACK} lockState_t;

  typedef struct packed {
    logic shift;    // a bit is accepted this cycle
    logic usePred;  // reference feeds on its own prediction
    logic cntBit;   // count a compared bit
    logic cntErr;   // count an error
    logic clrCnt;   // zero both counters
  } ctlStrobe_t;

  // index of the long tap (k-1)
  function automatic logic [4:0] idxLong(input logic [2:0] sel);
    case (sel)
      3'd0:    idxLong = 5'd6;
      3'd1:    idxLong = 5'd8;
      3'd2:    idxLong = 5'd14;
      3'd3:    idxLong = 5'd22;
      default: idxLong = 5'd30;
    endcase
  endfunction

  // index of the short tap (t-1)
  function automatic logic [4:0] idxShort(input logic [2:0] sel);
    case (sel)
      3'd0:    idxShort = 5'd5;
      3'd1:    idxShort = 5'd4;
      3'd2:    idxShort = 5'd13;
      3'd3:    idxShort = 5'd17;
      default: idxShort = 5'd27;
    endcase
  endfunction

endpackage

// File: rtl/prbs_chk_satcnt.sv
module prbs_chk_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (clr)            count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (count == TOP && !clr) |=> (count == TOP)); // R8

endmodule

// File: rtl/prbs_chk_datapath.sv
module prbs_chk_datapath
  import prbs_chk_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  logic [2:0]       orderSel,
  input  logic             fbInv,
  input  ctlStrobe_t       strobe,
  output logic             mismatch,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] bitCount,
  output logic             errPulse
);

  logic [HIST_W-1:0] hist;
  logic              predBit;
  logic [4:0]        tapL;
  logic [4:0]        tapS;

  always_comb begin
    tapL     = idxLong(orderSel);
    tapS     = idxShort(orderSel);
    predBit  = hist[tapL] ^ hist[tapS] ^ fbInv;
    mismatch = predBit ^ rxBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist     <= '0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= strobe.cntErr;
      if (strobe.shift)
        hist <= {hist[HIST_W-2:0], strobe.usePred ? predBit : rxBit};
    end
  end

  logic [1:0]       incVec;
  logic [CNT_W-1:0] cntVals [2];

  assign incVec = {strobe.cntErr, strobe.cntBit};

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    prbs_chk_satcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (strobe.clrCnt),
      .inc   (incVec[i]),
      .count (cntVals[i])
    );
  end

  assign bitCount = cntVals[0];
  assign errCount = cntVals[1];

  AST_PULSE_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> ($past(strobe.clrCnt) || $past(errCount) == '1 ||
                  errCount == CNT_W'($past(errCount) + 1'b1))); // R6

endmodule

// File: rtl/prbs_chk_ctrl.sv
module prbs_chk_ctrl
  import prbs_chk_pkg::*;
#(
  parameter int WIN_LEN   = 4096,
  parameter int ERR_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       clear,
  input  logic [2:0] orderSel,
  input  logic       mismatch,
  output ctlStrobe_t strobe,
  output logic       locked
);

  localparam int WC_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam int WE_W = $clog2(ERR_LIMIT + 1);
  localparam logic [WC_W-1:0] WIN_END  = WC_W'(WIN_LEN - 1);
  localparam logic [WE_W-1:0] ERR_LAST = WE_W'(ERR_LIMIT - 1);

  lockState_t      state;
  logic [6:0]      seekCnt;
  logic [6:0]      kLen;
  logic [6:0]      lockAt;
  logic [WC_W-1:0] winCnt;
  logic [WE_W-1:0] winErr;

  always_comb begin
    kLen   = {2'b00, idxLong(orderSel)} + 7'd1;
    lockAt = 7'(kLen * 7'd3 - 7'd1);
    locked = (state == TRACK);
    strobe.shift   = bitValid;
    strobe.usePred = locked;
    strobe.cntBit  = locked && bitValid;
    strobe.cntErr  = locked && bitValid && mismatch;
    strobe.clrCnt  = clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEEK;
      seekCnt <= '0;
      winCnt  <= '0;
      winErr  <= '0;
    end else if (bitValid) begin
      if (state == SEEK) begin
        if (seekCnt < kLen)      seekCnt <= seekCnt + 7'd1;
        else if (mismatch)       seekCnt <= '0;
        else if (seekCnt == lockAt) begin
          state  <= TRACK;
          winCnt <= '0;
          winErr <= '0;
        end else                 seekCnt <= seekCnt + 7'd1;
      end else begin
        if (mismatch && winErr == ERR_LAST) begin
          state   <= SEEK;
          seekCnt <= '0;
        end else if (winCnt == WIN_END) begin
          winCnt <= '0;
          winErr <= '0;
        end else begin
          winCnt <= winCnt + 1'b1;
          if (mismatch) winErr <= winErr + 1'b1;
        end
      end
    end
  end

  AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(bitValid && !mismatch)); // R4

  AST_WINDOW_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (winErr < WE_W'(ERR_LIMIT))); // R7

endmodule

// File: rtl/prbs_err_checker.sv
module prbs_err_checker
  import prbs_chk_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int WIN_LEN     = 4096,
  parameter int ERR_LIMIT   = 16,
  parameter int ENOUGH_ERRS = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             rxBit,
  input  logic [2:0]       orderSel,
  input  logic             fbInv,
  input  logic             clear,
  output logic [CNT_W-1:0] errCount,
  output logic [CNT_W-1:0] bitCount,
  output logic             locked,
  output logic             errPulse,
  output logic             enoughErrs
);

  ctlStrobe_t strobe;
  logic       mismatch;

  prbs_chk_ctrl #(.WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (bitValid),
    .clear    (clear),
    .orderSel (orderSel),
    .mismatch (mismatch),
    .strobe   (strobe),
    .locked   (locked)
  );

  prbs_chk_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxBit    (rxBit),
    .orderSel (orderSel),
    .fbInv    (fbInv),
    .strobe   (strobe),
    .mismatch (mismatch),
    .errCount (errCount),
    .bitCount (bitCount),
    .errPulse (errPulse)
  );

  assign enoughErrs = (errCount >= CNT_W'(ENOUGH_ERRS));

  AST_COUNT_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !clear) |=> $stable(bitCount)); // R9

endmodule

// File: tb/tb_prbs_err_checker.sv
module tb_prbs_err_checker;

  localparam int CW   = 12;
  localparam int WL   = 64;
  localparam int EL   = 8;
  localparam int MAXC = 4095;

  logic clk = 1'b0, rstN = 1'b0, bitValid = 1'b0, rxBit = 1'b0;
  logic fbInv = 1'b0, clear = 1'b0;
  logic [2:0] orderSel = 3'd0;
  logic [CW-1:0] errCount, bitCount;
  logic locked, errPulse, enoughErrs;

  always #5 clk = ~clk;

  prbs_err_checker #(.CNT_W(CW), .WIN_LEN(WL), .ERR_LIMIT(EL), .ENOUGH_ERRS(100)) dut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .rxBit(rxBit),
    .orderSel(orderSel), .fbInv(fbInv), .clear(clear),
    .errCount(errCount), .bitCount(bitCount), .locked(locked),
    .errPulse(errPulse), .enoughErrs(enoughErrs)
  );

  typedef struct { bit lk; bit ep; int bc; int ec; bit en; } exp_t;
  exp_t expQ[$];
  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // requirement-level model
  bit [30:0] mHist;
  bit mLocked;
  int mSeek, mWin, mWinErr, mBits, mErrs, mK, mT;
  bit mInv;
  // stream generator
  bit [30:0] g;
  int gK, gT;
  bit gInv;

  function automatic int tapK(int sel);
    case (sel) 0: return 7; 1: return 9; 2: return 15; 3: return 23; default: return 31; endcase
  endfunction
  function automatic int tapT(int sel);
    case (sel) 0: return 6; 1: return 5; 2: return 14; 3: return 18; default: return 28; endcase
  endfunction

  function automatic bit genNext();
    bit nb;
    nb = g[gK-1] ^ g[gT-1] ^ gInv;
    g = {g[29:0], nb};
    return nb;
  endfunction

  function automatic exp_t modelStep(bit v, bit b, bit clr);
    exp_t e;
    bit pred, mis, pulse;
    pulse = 0;
    if (v) begin
      pred = mHist[mK-1] ^ mHist[mT-1] ^ mInv;
      mis  = pred != b;
      if (!mLocked) begin
        if (mSeek < mK) mSeek++;
        else if (mis) mSeek = 0;
        else if (mSeek == 3*mK-1) begin mLocked = 1; mWin = 0; mWinErr = 0; end
        else mSeek++;
        mHist = {mHist[29:0], b};
      end else begin
        if (mBits < MAXC) mBits++;
        if (mis) begin pulse = 1; if (mErrs < MAXC) mErrs++; end
        if (mis && mWinErr + 1 == EL) begin mLocked = 0; mSeek = 0; end
        else if (mWin == WL-1) begin mWin = 0; mWinErr = 0; end
        else begin mWin++; if (mis) mWinErr++; end
        mHist = {mHist[29:0], pred};
      end
    end
    if (clr) begin mBits = 0; mErrs = 0; end
    e.lk = mLocked; e.ep = pulse; e.bc = mBits; e.ec = mErrs; e.en = (mErrs >= 100);
    return e;
  endfunction

  // monitor: compares one expected item per driven cycle
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk("R4/R7 locked", int'(locked), int'(e.lk));
      chk("R6 errPulse", int'(errPulse), int'(e.ep));
      chk("R9/R8 bitCount", int'(bitCount), e.bc);
      chk("R6/R8 errCount", int'(errCount), e.ec);
      chk("R10 enoughErrs", int'(enoughErrs), int'(e.en));
    end
  end

  // driver: drives one cycle and pushes what the outputs must show
  task automatic drive(bit v, bit b, bit clr);
    exp_t e;
    @(negedge clk);
    bitValid = v; rxBit = b; clear = clr;
    e = modelStep(v, b, clr);
    @(posedge clk);
    #1;
    expQ.push_back(e);
  endtask

  task automatic sendClean(int n);
    for (int i = 0; i < n; i++) drive(1, genNext(), 0);
  endtask

  task automatic sendErr();
    drive(1, ~genNext(), 0);
  endtask

  task automatic idle();
    drive(0, 0, 0);
  endtask

  task automatic setup(int sel, bit chkInv, bit genInv);
    @(negedge clk);
    rstN = 0; bitValid = 0; clear = 0;
    orderSel = 3'(sel); fbInv = chkInv;
    repeat (2) @(negedge clk);
    expQ.delete();
    mHist = '0; mLocked = 0; mSeek = 0; mWin = 0; mWinErr = 0; mBits = 0; mErrs = 0;
    mK = tapK(sel); mT = tapT(sel); mInv = chkInv;
    g = 31'h1; gK = tapK(sel); gT = tapT(sel); gInv = genInv;
    rstN = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11 locked", int'(locked), 0);
    chk("R11 bitCount", int'(bitCount), 0);
    chk("R11 errCount", int'(errCount), 0);
    chk("R11 errPulse", int'(errPulse), 0);

    // R4: order 7, gaps between bits do not advance acquisition
    setup(0, 0, 0);
    for (int i = 0; i < 20; i++) begin sendClean(1); idle(); end
    chk("R4 not locked after 3k-1", int'(locked), 0);
    sendClean(1);
    chk("R4 locked at 3k", int'(locked), 1);
    sendClean(100);
    chk("R9 bitCount after 100", int'(bitCount), 100);

    // R5/R6: single error costs one count and one pulse
    sendErr();
    chk("R6 errPulse on error", int'(errPulse), 1);
    chk("R6 errCount one", int'(errCount), 1);
    sendClean(1);
    chk("R6 pulse one cycle", int'(errPulse), 0);
    sendClean(30);
    chk("R5 no extra errors", int'(errCount), 1);

    // R9: clear wins over increment
    drive(1, genNext(), 1);
    chk("R9 clear bitCount", int'(bitCount), 0);
    chk("R9 clear errCount", int'(errCount), 0);

    // R7: dense burst drops lock, clean stream relocks
    for (int i = 0; i < 16; i++) sendErr();
    chk("R7 lock dropped", int'(locked), 0);
    sendClean(60);
    chk("R7 relocked", int'(locked), 1);

    // R3: mismatch during acquisition restarts loading
    setup(1, 0, 0);
    sendClean(20);
    sendErr();
    sendClean(26);
    chk("R3 not yet locked", int'(locked), 0);
    sendClean(1);
    chk("R3 locked after restart", int'(locked), 1);

    // R2: XNOR stream never locks an XOR checker
    setup(2, 0, 1);
    sendClean(200);
    chk("R2 no lock on wrong feedback", int'(locked), 0);
    setup(2, 1, 1);
    sendClean(45);
    chk("R2 XNOR lock order 15", int'(locked), 1);

    // R1: order 23 and unused code 6 meaning order 31
    setup(3, 0, 0);
    sendClean(69);
    chk("R1 lock order 23", int'(locked), 1);
    sendClean(50);
    setup(6, 1, 1);
    sendClean(93);
    chk("R1 lock code 6 as order 31", int'(locked), 1);
    sendClean(300);
    chk("R1 clean order 31 errors", int'(errCount), 0);

    // R10 and R7: sparse errors keep lock, flag at 100 errors
    setup(0, 0, 0);
    sendClean(21);
    for (int i = 0; i < 990; i++) if (i % 10 == 9) sendErr(); else sendClean(1);
    chk("R10 flag low at 99", int'(enoughErrs), 0);
    for (int i = 990; i < 1000; i++) if (i % 10 == 9) sendErr(); else sendClean(1);
    chk("R10 flag high at 100", int'(enoughErrs), 1);
    chk("R7 sparse errors keep lock", int'(locked), 1);

    // R8: saturation
    sendClean(3200);
    chk("R8 bitCount saturated", int'(bitCount), MAXC);
    chk("R8 errCount held", int'(errCount), 100);

    idle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule